// File: doc/BRIEF.md
# Double-Step Xorshift-Rotate Random Word Generator

This block is a pseudo-random word source built on a 32-bit state. The state is held as two 16-bit halves, `w0` and `w1`, and it uses the xoroshiro32+ style rotate/xor update. Each accepted request runs two iterations of the update inside one clock. It returns one 32-bit word that holds both 16-bit sums, so a consumer that reads 32 bits per request sees exactly the stream a single-step generator would emit 16 bits at a time.

A direction input makes the same request walk the state backward by two iterations instead. A reverse request reproduces the sums of the matching forward request with its two halves exchanged. A 16-bit addend can be folded into both sums, and a zero addend gives the plain generator. Two rotate/shift triplets are built: [14,2,7] and [15,3,6] by default, both set by parameters. A select input picks one of them for each request.

The seed is loaded through its own strobe. A seed of zero would freeze the generator, so it is swapped for a fixed nonzero value. Results are registered, and a request can be issued on every cycle.

Top module: `dstep_xoro_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `result` is 0 and `result_valid` is 0. The state is `RESET_SEED` (default 32'h0000_0001), with `w0` taken from bits [15:0] and `w1` from bits [31:16].
- R2: A cycle with `seed_load`=1 loads `w0`=`seed`[15:0] and `w1`=`seed`[31:16]. An all-zero seed loads `ZERO_SUB` (default 32'h0000_0001) instead. A load wins over `step_req` in the same cycle, and that cycle produces no valid result.
- R3: A forward request (`dir_back`=0) runs two iterations from the current state. One iteration is: t = w1^w0, w0' = rotl(w0,a) ^ t ^ (t<<b), w1' = rotl(t,c). The sum of each iteration is w0+w1+addend mod 2^16, taken on the state before that iteration.
- R4: The sum of the first iteration sits in `result`[15:0] and the second in `result`[31:16]. Back-to-back forward requests therefore produce the single-step 16-bit stream, low half first.
- R5: A reverse request (`dir_back`=1) undoes two iterations. The low half is the sum of the state one step back and the high half is the sum of the state two steps back. A forward request followed by a reverse request with the same addend and triplet returns the state, and the second result equals the first with its halves exchanged.
- R6: `addend` is added into both 16-bit sums of its request. With `addend`=0 the sums are plain w0+w1.
- R7: `trip_sel`=0 selects triplet [a,b,c]=[14,2,7] and `trip_sel`=1 selects [15,3,6], sampled per request.
- R8: `result_valid` is 1 in the cycle after a request that has no load beside it, and 0 otherwise. A request is accepted on every cycle.
- R9: The state is never all-zero outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed` into the state |
| seed | input | 32 | Seed word; low half to w0, high half to w1 |
| step_req | input | 1 | Request one double step |
| dir_back | input | 1 | 0 steps forward, 1 steps backward |
| trip_sel | input | 1 | Triplet choice for this request |
| addend | input | 16 | Value added into both sums |
| result | output | 32 | Two packed 16-bit sums |
| result_valid | output | 1 | `result` holds a new word |

## Verification
The hardest situation to reach from the ports is a reverse step that lands on a state the bench can confirm. The state is never visible, so the only evidence of a correct reverse is the sums it emits. The stimulus therefore pairs each forward request with a reverse request of the same addend and triplet. The bench checks the second word against the first with its halves exchanged, and it also runs long reverse walks and compares them with an independent backward model. Loading a zero seed while a step request is raised, and switching triplet between back-to-back requests, reach the substitution and the per-request selection.

// File: rtl/xr_pkg.sv
package xr_pkg;

   typedef enum logic {
      XR_FWD = 1'b0,
      XR_REV = 1'b1
   } xr_dir_e;

   localparam int XR_HALF_W   = 16;
   localparam int XR_NUM_TRIP = 2;

endpackage

// File: rtl/xr_iter.sv
module xr_iter #(
   parameter int HW      = 16,
   parameter int ROT_A   = 14,
   parameter int SHF_B   = 2,
   parameter int ROT_C   = 7,
   parameter bit REVERSE = 1'b0
) (
   input  logic [HW-1:0] in_w0,
   input  logic [HW-1:0] in_w1,
   output logic [HW-1:0] out_w0,
   output logic [HW-1:0] out_w1
);

   if (ROT_A < 1 || ROT_A > HW-1) begin : g_bad_a
      $error("xr_iter: ROT_A out of range");
   end
   if (SHF_B < 1 || SHF_B > HW-1) begin : g_bad_b
      $error("xr_iter: SHF_B out of range");
   end
   if (ROT_C < 1 || ROT_C > HW-1) begin : g_bad_c
      $error("xr_iter: ROT_C out of range");
   end

   localparam int INV_A = HW - ROT_A;
   localparam int INV_C = HW - ROT_C;

   logic [HW-1:0] mix_t;
   logic [HW-1:0] mix_m;

   if (!REVERSE) begin : g_fwd
      always_comb begin
         mix_t  = in_w1 ^ in_w0;
         mix_m  = (in_w0 << ROT_A) | (in_w0 >> INV_A);
         out_w0 = mix_m ^ mix_t ^ (mix_t << SHF_B);
         out_w1 = (mix_t << ROT_C) | (mix_t >> INV_C);
      end
   end else begin : g_rev
      always_comb begin
         mix_t  = (in_w1 << INV_C) | (in_w1 >> ROT_C);
         mix_m  = in_w0 ^ mix_t ^ (mix_t << SHF_B);
         out_w0 = (mix_m << INV_A) | (mix_m >> ROT_A);
         out_w1 = mix_t ^ out_w0;
      end
   end

endmodule

// File: rtl/xr_dstep.sv
module xr_dstep
   import xr_pkg::*;
#(
   parameter int HW    = 16,
   parameter int ROT_A = 14,
   parameter int SHF_B = 2,
   parameter int ROT_C = 7
) (
   input  logic [HW-1:0] cur_w0,
   input  logic [HW-1:0] cur_w1,
   input  logic [HW-1:0] addend,
   input  xr_dir_e       dir,
   output logic [HW-1:0] nxt_w0,
   output logic [HW-1:0] nxt_w1,
   output logic [HW-1:0] sum_lo,
   output logic [HW-1:0] sum_hi
);

   localparam int NSTEP = 2;

   // chain index 0 is the current state; index k is k iterations away
   logic [HW-1:0] fw0 [NSTEP+1];
   logic [HW-1:0] fw1 [NSTEP+1];
   logic [HW-1:0] rw0 [NSTEP+1];
   logic [HW-1:0] rw1 [NSTEP+1];

   assign fw0[0] = cur_w0;
   assign fw1[0] = cur_w1;
   assign rw0[0] = cur_w0;
   assign rw1[0] = cur_w1;

   for (genvar k = 0; k < NSTEP; k++) begin : g_chain
      xr_iter #(
         .HW(HW), .ROT_A(ROT_A), .SHF_B(SHF_B), .ROT_C(ROT_C), .REVERSE(1'b0)
      ) u_fwd (
         .in_w0(fw0[k]), .in_w1(fw1[k]), .out_w0(fw0[k+1]), .out_w1(fw1[k+1])
      );
      xr_iter #(
         .HW(HW), .ROT_A(ROT_A), .SHF_B(SHF_B), .ROT_C(ROT_C), .REVERSE(1'b1)
      ) u_rev (
         .in_w0(rw0[k]), .in_w1(rw1[k]), .out_w0(rw0[k+1]), .out_w1(rw1[k+1])
      );
   end

   logic [HW-1:0] lo_a, lo_b, hi_a, hi_b;

   always_comb begin
      if (dir == XR_REV) begin
         lo_a   = rw0[1];
         lo_b   = rw1[1];
         hi_a   = rw0[2];
         hi_b   = rw1[2];
         nxt_w0 = rw0[NSTEP];
         nxt_w1 = rw1[NSTEP];
      end else begin
         lo_a   = fw0[0];
         lo_b   = fw1[0];
         hi_a   = fw0[1];
         hi_b   = fw1[1];
         nxt_w0 = fw0[NSTEP];
         nxt_w1 = fw1[NSTEP];
      end
      sum_lo = lo_a + lo_b + addend;
      sum_hi = hi_a + hi_b + addend;
   end

endmodule

// File: rtl/dstep_xoro_gen.sv
module dstep_xoro_gen
   import xr_pkg::*;
#(
   parameter int          HW         = XR_HALF_W,
   parameter int          TRIP0_A    = 14,
   parameter int          TRIP0_B    = 2,
   parameter int          TRIP0_C    = 7,
   parameter int          TRIP1_A    = 15,
   parameter int          TRIP1_B    = 3,
   parameter int          TRIP1_C    = 6,
   parameter logic [31:0] RESET_SEED = 32'h0000_0001,
   parameter logic [31:0] ZERO_SUB   = 32'h0000_0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_load,
   input  logic [2*HW-1:0]  seed,
   input  logic             step_req,
   input  logic             dir_back,
   input  logic             trip_sel,
   input  logic [HW-1:0]    addend,
   output logic [2*HW-1:0]  result,
   output logic             result_valid
);

   localparam int SW = 2 * HW;
   localparam int NT = XR_NUM_TRIP;
   localparam int TA [NT] = '{TRIP0_A, TRIP1_A};
   localparam int TB [NT] = '{TRIP0_B, TRIP1_B};
   localparam int TC [NT] = '{TRIP0_C, TRIP1_C};
   localparam logic [SW-1:0] RST_V = RESET_SEED[SW-1:0];
   localparam logic [SW-1:0] SUB_V = ZERO_SUB[SW-1:0];

   if (HW < 4 || SW > 32) begin : g_bad_hw
      $error("dstep_xoro_gen: HW must lie in 4..16");
   end
   if (RST_V == '0) begin : g_bad_rst
      $error("dstep_xoro_gen: RESET_SEED must be nonzero");
   end
   if (SUB_V == '0) begin : g_bad_sub
      $error("dstep_xoro_gen: ZERO_SUB must be nonzero");
   end

   logic [HW-1:0] w0_q, w1_q;
   logic [SW-1:0] result_q;
   logic          valid_q;
   xr_dir_e       dir;

   assign dir = xr_dir_e'(dir_back);

   logic [HW-1:0] t_nw0 [NT];
   logic [HW-1:0] t_nw1 [NT];
   logic [HW-1:0] t_slo [NT];
   logic [HW-1:0] t_shi [NT];

   for (genvar g = 0; g < NT; g++) begin : g_trip
      xr_dstep #(
         .HW(HW), .ROT_A(TA[g]), .SHF_B(TB[g]), .ROT_C(TC[g])
      ) u_dstep (
         .cur_w0(w0_q),
         .cur_w1(w1_q),
         .addend(addend),
         .dir(dir),
         .nxt_w0(t_nw0[g]),
         .nxt_w1(t_nw1[g]),
         .sum_lo(t_slo[g]),
         .sum_hi(t_shi[g])
      );
   end

   logic [HW-1:0] sel_w0, sel_w1, sel_lo, sel_hi;
   logic [SW-1:0] seed_eff;

   always_comb begin
      sel_w0   = t_nw0[trip_sel];
      sel_w1   = t_nw1[trip_sel];
      sel_lo   = t_slo[trip_sel];
      sel_hi   = t_shi[trip_sel];
      seed_eff = (seed == '0) ? SUB_V : seed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w0_q     <= RST_V[HW-1:0];
         w1_q     <= RST_V[SW-1:HW];
         result_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= step_req && !seed_load;
         if (seed_load) begin
            w0_q <= seed_eff[HW-1:0];
            w1_q <= seed_eff[SW-1:HW];
         end else if (step_req) begin
            w0_q     <= sel_w0;
            w1_q     <= sel_w1;
            result_q <= {sel_hi, sel_lo};
         end
      end
   end

   assign result       = result_q;
   assign result_valid = valid_q;

   // R8
   valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && !seed_load) |=> result_valid);

   // R8
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_req && !seed_load) |=> !result_valid);

   // R9
   state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_req |-> ({w1_q, w0_q} != '0));

   // R2
   seed_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> ({w1_q, w0_q} ==
                     (($past(seed) == '0) ? SUB_V : $past(seed))));

   // R3
   fwd_low_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && !seed_load && !dir_back) |=>
      (result[HW-1:0] == HW'($past(w0_q) + $past(w1_q) + $past(addend))));

endmodule

// File: tb/dstep_xoro_gen_test.sv
module dstep_xoro_gen_test;

   localparam int PER = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [31:0] seed = '0;
   logic        step_req = 1'b0;
   logic        dir_back = 1'b0;
   logic        trip_sel = 1'b0;
   logic [15:0] addend = '0;
   logic [31:0] result;
   logic        result_valid;

   dstep_xoro_gen uut (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
      .step_req(step_req), .dir_back(dir_back), .trip_sel(trip_sel),
      .addend(addend), .result(result), .result_valid(result_valid)
   );

   always #(PER/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          tag;
      logic [31:0] exp;
      string       req;
   } sb_item_t;
   sb_item_t sbq[$];

   // reference model of the state, written from the requirements
   logic [15:0] m0 = 16'h0001;
   logic [15:0] m1 = 16'h0000;

   function automatic logic [15:0] rl(input logic [15:0] x, input int n);
      return 16'((x << n) | (x >> (16 - n)));
   endfunction

   function automatic void trip(input logic s, output int a, output int b,
                                output int c);
      if (s) begin a = 15; b = 3; c = 6; end
      else   begin a = 14; b = 2; c = 7; end
   endfunction

   task automatic m_fwd(input logic s);
      int a, b, c;
      logic [15:0] t;
      trip(s, a, b, c);
      t  = m1 ^ m0;
      m0 = rl(m0, a) ^ t ^ 16'(t << b);
      m1 = rl(t, c);
   endtask

   task automatic m_rev(input logic s);
      int a, b, c;
      logic [15:0] t, m;
      trip(s, a, b, c);
      t  = rl(m1, 16 - c);
      m  = m0 ^ t ^ 16'(t << b);
      m0 = rl(m, 16 - a);
      m1 = t ^ m0;
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: called at a negedge, returns at the next negedge
   task automatic issue(input logic back, input logic s, input logic [15:0] ad,
                        input string req);
      sb_item_t it;
      logic [15:0] lo, hi;
      if (!back) begin
         lo = m0 + m1 + ad; m_fwd(s);
         hi = m0 + m1 + ad; m_fwd(s);
      end else begin
         m_rev(s); lo = m0 + m1 + ad;
         m_rev(s); hi = m0 + m1 + ad;
      end
      it.tag = cyc; it.exp = {hi, lo}; it.req = req;
      sbq.push_back(it);
      step_req = 1'b1; seed_load = 1'b0;
      dir_back = back; trip_sel = s; addend = ad;
      @(negedge clk);
   endtask

   task automatic idle();
      step_req = 1'b0; seed_load = 1'b0;
      @(negedge clk);
   endtask

   task automatic load(input logic [31:0] v, input logic with_step);
      seed = v; seed_load = 1'b1; step_req = with_step;
      if (v == 32'h0) begin m0 = 16'h0001; m1 = 16'h0000; end
      else begin m0 = v[15:0]; m1 = v[31:16]; end
      @(negedge clk);
      seed_load = 1'b0; step_req = 1'b0;
      @(negedge clk);
      // R2: load beside a request gives no valid result
      check(result_valid == 1'b0, "R2 no valid on load", {31'b0, result_valid}, 32'h0);
   endtask

   // monitor: pops an item one cycle after it was issued
   initial begin
      forever begin
         @(negedge clk);
         if (sbq.size() > 0 && sbq[0].tag + 1 == cyc) begin
            check(result_valid === 1'b1, {sbq[0].req, " R8 valid"},
                  {31'b0, result_valid}, 32'h1);
            check(result === sbq[0].exp, sbq[0].req, result, sbq[0].exp);
            void'(sbq.pop_front());
         end else if (result_valid !== 1'b0) begin
            check(1'b0, "R8 stray valid", {31'b0, result_valid}, 32'h0);
         end
      end
   end

   initial begin
      #(PER * 100000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   logic [31:0] w_f, w_r;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(result == 32'h0, "R1 result in reset", result, 32'h0);
      check(result_valid == 1'b0, "R1 valid in reset", {31'b0, result_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(result == 32'h0 && !result_valid, "R1 after reset", result, 32'h0);

      // R3 R4 R8: back-to-back forward requests from the reset seed
      for (int i = 0; i < 8; i++) issue(1'b0, 1'b0, 16'h0, "R3 R4 fwd");
      idle();
      // R8 idle cycle shows no valid
      check(result_valid == 1'b0, "R8 idle", {31'b0, result_valid}, 32'h0);

      // R2 load beside a request
      load(32'h1234_ABCD, 1'b1);
      for (int i = 0; i < 4; i++) issue(1'b0, 1'b0, 16'h0, "R2 R3 after load");

      // R6 addend
      for (int i = 0; i < 4; i++) issue(1'b0, 1'b0, 16'h7777, "R6 addend");
      issue(1'b0, 1'b0, 16'hFFFF, "R6 addend wrap");
      issue(1'b0, 1'b0, 16'h0000, "R6 zero addend");

      // R5 round trip: forward then reverse
      idle();
      issue(1'b0, 1'b0, 16'h0042, "R5 fwd leg");
      w_f = result;
      idle();
      issue(1'b1, 1'b0, 16'h0042, "R5 rev leg");
      w_r = result;
      idle();
      check(w_r == {w_f[15:0], w_f[31:16]}, "R5 swapped halves", w_r,
            {w_f[15:0], w_f[31:16]});
      for (int i = 0; i < 6; i++) issue(1'b1, 1'b0, 16'h0, "R5 rev walk");
      for (int i = 0; i < 6; i++) issue(i[0], 1'b0, 16'h0010, "R5 alternate");

      // R7 second triplet, switching per request
      for (int i = 0; i < 5; i++) issue(1'b0, 1'b1, 16'h0, "R7 trip1 fwd");
      issue(1'b1, 1'b1, 16'h0, "R7 trip1 rev");
      for (int i = 0; i < 6; i++) issue(1'b0, i[0], 16'h0003, "R7 mixed");
      idle();
      issue(1'b0, 1'b1, 16'h0005, "R7 R5 fwd");
      w_f = result;
      issue(1'b1, 1'b1, 16'h0005, "R7 R5 rev");
      w_r = result;
      idle();
      check(w_r == {w_f[15:0], w_f[31:16]}, "R7 R5 swapped halves", w_r,
            {w_f[15:0], w_f[31:16]});

      // R2 R9 zero seed is replaced
      load(32'h0, 1'b0);
      for (int i = 0; i < 3; i++) issue(1'b0, 1'b0, 16'h0, "R2 R9 zero seed");
      load(32'h0, 1'b1);
      issue(1'b1, 1'b0, 16'h0, "R2 R9 zero seed rev");
      idle();
      idle();
      check(sbq.size() == 0, "R8 all results seen", sbq.size(), 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule